// File: doc/BRIEF.md
# Radix-4 Signed-Digit Divider

This block divides two normalized fixed-point operands, each of the form 1.xxx (one integer bit, `DW-1` fraction bits, leading bit set). It produces two quotient bits per clock. Each step picks a quotient digit from {-2, -1, 0, +1, +2} by comparing a short estimate of the partial remainder with multiples of a short estimate of the divisor. The partial remainder is kept as a sum vector and a carry vector, so no step waits on a full-width carry chain. Only the top eight bits of the remainder are added together, to form the estimate.

Positive digits and the magnitudes of negative digits go into two separate shift registers. One subtraction after the last step merges them into a plain unsigned quotient with two integer bits. The caller pulses `start` with both operands while the block is idle. It reads `quotient` when `done` pulses. Normalizing the operands beforehand, scaling the result afterwards, correcting the remainder and rounding are all left to the surrounding logic.

Top module: `srt4_divider`

## Requirements
- R1: `start` is accepted only when idle. After an accepted start, `done` goes high for exactly one cycle, `ITER+1` clock edges after the accepting edge, and never two cycles in a row.
- R2: A `start` that arrives while a division is in progress is ignored. The operands in progress are kept, and the ignored request produces no extra `done`.
- R3: The true partial remainder (sum plus carry, two's complement, 4 integer bits) stays within ±8/3 of the divisor at every step. The 8-bit remainder estimate stays inside ±6.
- R4: Every quotient digit is one of {-2, -1, 0, +1, +2}. The digit is encoded as a sign flag plus a 2-bit magnitude, and there is no negative zero. Positive digits shift into one register and negative magnitudes into the other, and the quotient is their difference.
- R5: For any normalized operands, the quotient Q, read as an unsigned value with 2 integer bits and `2*ITER-2` fraction bits, satisfies |Q - X/D| ≤ 2/3 of one quotient ulp.
- R6: Equal operands give exactly 1.0, that is `1 << (2*ITER-2)`.
- R7: `quotient` keeps its value in every cycle where `done` is low.
- R8: During reset and right after it, `done` is 0 and `quotient` is 0.
- R9: The extreme ratios meet R5 without overflow of the 2 integer bits. These are the largest dividend over the smallest divisor (quotient just under 2) and the smallest dividend over the largest divisor (just over 1/2).
- R10: A `start` driven in the same cycle that `done` is high is accepted. That division completes with the R1 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a division with the presented operands |
| dividend | input | DW | Dividend, 1.xxx, bit DW-1 set |
| divisor | input | DW | Divisor, 1.xxx, bit DW-1 set |
| done | output | 1 | One-cycle pulse: `quotient` holds a new result |
| quotient | output | 2*ITER | Unsigned quotient, 2 integer bits |

## Verification
The bound checker watches the redundant state on every cycle. It checks that the assimilated remainder stays within ±8/3·D and that the estimate stays in its band. It also checks that each selected digit is a legal signed digit, that `done` is a single pulse tied to a busy period, that a start while busy leaves the held divisor alone, and that the output holds between pulses. Only the bench scenarios can show that the merged quotient is arithmetically right (the 2/3-ulp bound over random and extreme operands, and the exact 1.0 case). They also show the exact latency, the rejection of a mid-flight start as seen at the result, and back-to-back acceptance in the done cycle.

// File: rtl/srt4_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the radix-4 signed-digit divider.
// Assumes: remainder estimate of 4 integer + 4 fraction bits, divisor
// estimate of 1 integer + 4 fraction bits.
package srt4_pkg;

    // Estimate widths and the band the remainder estimate can ever reach.
    localparam int EST_W    = 8;
    localparam int EST_FRAC = 4;
    localparam int DEST_W   = 5;
    localparam int EST_BAND = 6 << EST_FRAC;

    // Signed quotient digit: sign flag plus magnitude 0..2.
    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } sdigit_t;

    // Controller state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIN  = 2'd2
    } st_e;

endpackage

// File: rtl/srt4_qsel.sv
`timescale 1ns/1ps
// Quotient digit selection.
// Adds the top bits of the sum and carry vectors into a short remainder
// estimate and compares twice its value (in 1/32 units) against four
// thresholds derived from the truncated divisor. Positive thresholds use
// the truncated divisor, negative ones the truncated divisor plus one
// LSB, so that truncation error on either side stays inside the 1/6
// overlap margin. Estimates outside the reachable band select zero.
// Assumes: divisor estimate is 1.xxxx (value 16..31 in 1/16 units).
module srt4_qsel
    import srt4_pkg::*;
(
    input  logic [EST_W-1:0]        s_top,
    input  logic [EST_W-1:0]        c_top,
    input  logic [DEST_W-1:0]       d_top,
    output logic signed [EST_W-1:0] est,
    output sdigit_t                 dig
);

    localparam int TW = 11;

    logic signed [TW-1:0] r32;
    logic signed [TW-1:0] d_lo;
    logic signed [TW-1:0] d_hi;
    logic signed [TW-1:0] th_p2;
    logic signed [TW-1:0] th_p1;
    logic signed [TW-1:0] th_m1;
    logic signed [TW-1:0] th_m2;
    logic                 out_band;

    // Assimilate only the short estimate.
    assign est = $signed(s_top + c_top);

    // Thresholds at +3/2, +1/2, -1/2, -3/2 of the divisor estimate.
    always_comb begin
        r32   = $signed({{(TW-EST_W-1){est[EST_W-1]}}, est, 1'b0});
        d_lo  = $signed({{(TW-DEST_W){1'b0}}, d_top});
        d_hi  = d_lo + 11'sd1;
        th_p2 = (d_lo <<< 1) + d_lo;
        th_p1 = d_lo;
        th_m1 = -d_hi;
        th_m2 = -((d_hi <<< 1) + d_hi);
    end

    // Cells no valid remainder can reach answer zero.
    assign out_band = (est >= 8'(EST_BAND)) || (est < -8'(EST_BAND));

    // Pick the digit from the highest threshold exceeded.
    always_comb begin
        dig = '{neg: 1'b0, mag: 2'd0};
        if (out_band)          dig = '{neg: 1'b0, mag: 2'd0};
        else if (r32 > th_p2)  dig = '{neg: 1'b0, mag: 2'd2};
        else if (r32 > th_p1)  dig = '{neg: 1'b0, mag: 2'd1};
        else if (r32 > th_m1)  dig = '{neg: 1'b0, mag: 2'd0};
        else if (r32 > th_m2)  dig = '{neg: 1'b1, mag: 2'd1};
        else                   dig = '{neg: 1'b1, mag: 2'd2};
    end

endmodule

// File: rtl/srt4_csa.sv
`timescale 1ns/1ps
// One recurrence step in carry-save form: adds sum, carry and -q*D with
// a row of full adders, then shifts both vectors left by two (times 4).
// Only the low RW-2 bits of each input matter, because the two top bits
// fall off in the shift. For positive digits the inverted multiple is
// completed by a +1 injected into the free carry LSB.
// Assumes: divisor is DW bits 1.xxx, aligned to the remainder LSB.
module srt4_csa
    import srt4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW:0]   sum_i,
    input  logic [DW:0]   car_i,
    input  logic [DW-1:0] dvsr,
    input  sdigit_t       dig,
    output logic [DW+2:0] sum_o,
    output logic [DW+2:0] car_o
);

    localparam int LW = DW + 1;

    logic [LW-1:0] d1;
    logic [LW-1:0] d2;
    logic [LW-1:0] mq;
    logic          inj;
    logic [LW-1:0] fs;
    logic [LW-2:0] fc;

    assign d1 = {1'b0, dvsr};
    assign d2 = {dvsr, 1'b0};

    // Form -q*D and the matching carry-in.
    always_comb begin
        mq  = '0;
        inj = 1'b0;
        case ({dig.neg, dig.mag})
            3'b010:  begin mq = ~d2; inj = 1'b1; end
            3'b001:  begin mq = ~d1; inj = 1'b1; end
            3'b101:  mq = d1;
            3'b110:  mq = d2;
            default: mq = '0;
        endcase
    end

    // Row of full adders; majority bits only where they survive the shift.
    for (genvar i = 0; i < LW; i++) begin : g_fa
        assign fs[i] = sum_i[i] ^ car_i[i] ^ mq[i];
        if (i < LW - 1) begin : g_maj
            assign fc[i] = (sum_i[i] & car_i[i]) | (sum_i[i] & mq[i]) |
                           (car_i[i] & mq[i]);
        end
    end

    // Multiply the redundant remainder by four.
    assign sum_o = {fs, 2'b00};
    assign car_o = {fc, inj, 2'b00};

endmodule

// File: rtl/srt4_qacc.sv
`timescale 1ns/1ps
// Quotient collection: positive digits shift into one register and the
// magnitudes of negative digits into another, two bits per step, most
// significant digit first. Their difference is the unsigned quotient.
// Assumes: clr and shift_en are never high together.
module srt4_qacc
    import srt4_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift_en,
    input  sdigit_t       dig,
    output logic [QW-1:0] q_fin
);

    logic [QW-1:0] q_pos;
    logic [QW-1:0] q_neg;
    logic [1:0]    pos_bits;
    logic [1:0]    neg_bits;

    assign pos_bits = dig.neg ? 2'b00 : dig.mag;
    assign neg_bits = dig.neg ? dig.mag : 2'b00;

    // Shift the split digit registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q_pos <= '0;
            q_neg <= '0;
        end else if (shift_en) begin
            q_pos <= {q_pos[QW-3:0], pos_bits};
            q_neg <= {q_neg[QW-3:0], neg_bits};
        end
    end

    // Single carry-propagate merge.
    assign q_fin = q_pos - q_neg;

endmodule

// File: rtl/srt4_divider.sv
`timescale 1ns/1ps
// Radix-4 signed-digit divider, top level.
// Accepts two normalized operands (1.xxx) on start while idle, runs ITER
// recurrence steps on a carry-save remainder, then merges the split
// quotient registers and pulses done for one cycle.
// Assumes: bit DW-1 of both operands is set; ITER >= 2.
module srt4_divider
    import srt4_pkg::*;
#(
    parameter int DW   = 16,
    parameter int ITER = DW / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DW-1:0]     dividend,
    input  logic [DW-1:0]     divisor,
    output logic              done,
    output logic [2*ITER-1:0] quotient
);

    localparam int RW = DW + 3;
    localparam int QW = 2 * ITER;
    localparam int CW = $clog2(ITER + 1);
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    st_e                     st;
    logic [CW-1:0]           cnt;
    logic [RW-1:0]           rem_s;
    logic [RW-1:0]           rem_c;
    logic [RW-1:0]           nxt_s;
    logic [RW-1:0]           nxt_c;
    logic [DW-1:0]           dvsr_q;
    sdigit_t                 dig;
    logic signed [EST_W-1:0] est;
    logic [QW-1:0]           q_fin;
    logic                    accept;
    logic                    stepping;
    logic                    busy;

    assign accept   = (st == ST_IDLE) && start;
    assign stepping = (st == ST_ITER);
    assign busy     = (st != ST_IDLE);

    srt4_qsel u_qsel (
        .s_top (rem_s[RW-1 -: EST_W]),
        .c_top (rem_c[RW-1 -: EST_W]),
        .d_top (dvsr_q[DW-1 -: DEST_W]),
        .est   (est),
        .dig   (dig)
    );

    srt4_csa #(.DW(DW)) u_csa (
        .sum_i (rem_s[RW-3:0]),
        .car_i (rem_c[RW-3:0]),
        .dvsr  (dvsr_q),
        .dig   (dig),
        .sum_o (nxt_s),
        .car_o (nxt_c)
    );

    srt4_qacc #(.QW(QW)) u_qacc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .shift_en (stepping),
        .dig      (dig),
        .q_fin    (q_fin)
    );

    // Sequence idle -> ITER steps -> merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_ITER;
                    cnt <= '0;
                end
                ST_ITER: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) st <= ST_FIN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Load operands on accept, advance the redundant remainder per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_s  <= '0;
            rem_c  <= '0;
            dvsr_q <= '0;
        end else if (accept) begin
            rem_s  <= {3'b000, dividend};
            rem_c  <= '0;
            dvsr_q <= divisor;
        end else if (stepping) begin
            rem_s  <= nxt_s;
            rem_c  <= nxt_c;
        end
    end

    // Register the merged quotient and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            quotient <= '0;
        end else begin
            done <= (st == ST_FIN);
            if (st == ST_FIN) quotient <= q_fin;
        end
    end

endmodule

// File: rtl/srt4_divider_chk.sv
`timescale 1ns/1ps
// Protocol and datapath invariants of srt4_divider, bound into every
// instance. Assumes the top's internal names listed in the bind below.
module srt4_divider_chk
    import srt4_pkg::*;
#(
    parameter int DW = 16,
    parameter int QW = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    done,
    input logic                    busy,
    input logic [QW-1:0]           quotient,
    input logic [DW+2:0]           rem_s,
    input logic [DW+2:0]           rem_c,
    input logic [DW-1:0]           dvsr,
    input sdigit_t                 dig,
    input logic signed [EST_W-1:0] est
);

    localparam int RW = DW + 3;

    logic [RW-1:0] r_raw;
    logic [RW-1:0] r_mag;
    logic [RW+1:0] lhs;
    logic [RW+1:0] rhs;

    // Full assimilation of the remainder, for checking only.
    always_comb begin
        r_raw = rem_s + rem_c;
        r_mag = r_raw[RW-1] ? (~r_raw + 1'b1) : r_raw;
        lhs   = ({2'b00, r_mag} << 1) + {2'b00, r_mag};
        rhs   = {5'b00000, dvsr} << 3;
    end

    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_from_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_done_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dvsr));

    p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lhs <= rhs);

    p_est_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (est < 8'(EST_BAND)) && (est >= -8'(EST_BAND)));

    p_digit_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (dig.mag != 2'd3) && !(dig.neg && dig.mag == 2'd0));

    p_quot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quotient));

endmodule

bind srt4_divider srt4_divider_chk #(.DW(DW), .QW(QW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .busy     (busy),
    .quotient (quotient),
    .rem_s    (rem_s),
    .rem_c    (rem_c),
    .dvsr     (dvsr_q),
    .dig      (dig),
    .est      (est)
);

// File: tb/sim_srt4_divider.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues each accepted division, the
// monitor pops it on done and checks latency and accuracy.
module sim_srt4_divider;

    localparam int DW   = 16;
    localparam int ITER = 8;
    localparam int QW   = 2 * ITER;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] dividend = '0;
    logic [DW-1:0] divisor = '0;
    logic          done;
    logic [QW-1:0] quotient;

    typedef struct {
        logic [DW-1:0] x;
        logic [DW-1:0] d;
        int            t0;
        string         atag;
        string         ltag;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    n_done = 0;
    bit    finished = 0;

    srt4_divider #(.DW(DW), .ITER(ITER)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dividend (dividend),
        .divisor  (divisor),
        .done     (done),
        .quotient (quotient)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare each done against the oldest queued division.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "done with nothing pending", 1, 0);
            end else begin
                item_t  it;
                longint err;
                it  = sb.pop_front();
                check(cyc - it.t0 == ITER + 1, it.ltag, "latency",
                      cyc - it.t0, ITER + 1);
                err = longint'(quotient) * longint'(it.d) -
                      (longint'(it.x) <<< (QW - 2));
                if (err < 0) err = -err;
                check(3 * err <= 2 * longint'(it.d), it.atag,
                      "3*|Q*D - X| vs 2*D", 3 * err, 2 * longint'(it.d));
                if (it.x == it.d)
                    check(quotient == QW'(1) << (QW - 2), "R6", "equal operands",
                          quotient, longint'(1) <<< (QW - 2));
            end
            n_done++;
        end
    end

    // Driver: present operands at a negedge, queue them once accepted.
    task automatic issue(input logic [DW-1:0] x, input logic [DW-1:0] d,
                         input string atag, input string ltag);
        item_t it;
        start    = 1'b1;
        dividend = x;
        divisor  = d;
        @(posedge clk);
        #1;
        it.x = x; it.d = d; it.t0 = cyc; it.atag = atag; it.ltag = ltag;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input logic [DW-1:0] x, input logic [DW-1:0] d,
                       input string atag);
        int tgt;
        tgt = n_done + 1;
        issue(x, d, atag, "R1");
        wait (n_done == tgt);
    endtask

    initial begin
        logic [QW-1:0] held;
        int            base;
        void'($urandom(32'h5eed));

        // R8: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R8", "done in reset", done, 0);
        check(quotient == '0, "R8", "quotient in reset", quotient, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R8", "done after reset", done, 0);
        check(quotient == '0, "R8", "quotient after reset", quotient, 0);

        // R6: equal operands, exact one
        run(16'h8000, 16'h8000, "R6");
        run(16'hC3A5, 16'hC3A5, "R6");
        run(16'hFFFF, 16'hFFFF, "R6");

        // R9: extreme ratios
        run(16'hFFFF, 16'h8000, "R9");
        run(16'h8000, 16'hFFFF, "R9");
        run(16'hFFFE, 16'h8001, "R9");
        run(16'h8001, 16'hFFFE, "R9");

        // R3: divisors with maximal truncation error, ratios near digit edges
        run(16'hAAAA, 16'h8000, "R3");
        run(16'hFFFF, 16'h87FF, "R3");
        run(16'hD555, 16'h8FFF, "R3");
        run(16'hBFFF, 16'h87FF, "R3");
        run(16'hFFFF, 16'hBFFF, "R3");
        run(16'h8000, 16'hC000, "R3");
        run(16'hF7FF, 16'h9FFF, "R3");
        run(16'hC000, 16'h8800, "R3");

        // R2: a second start while busy must be ignored
        base = n_done;
        issue(16'h9000, 16'h9000, "R2", "R1");
        repeat (2) @(negedge clk);
        start = 1'b1; dividend = 16'hFFFF; divisor = 16'h8000;
        repeat (2) @(negedge clk);
        start = 1'b0;
        wait (n_done == base + 1);
        check(quotient == QW'(1) << (QW - 2), "R2", "result of first operands",
              quotient, longint'(1) <<< (QW - 2));

        // R7 and R2: no extra done, output held
        held = quotient;
        repeat (20) @(negedge clk);
        check(n_done == base + 1, "R2", "done count after ignored start",
              n_done, base + 1);
        check(quotient == held, "R7", "quotient hold", quotient, held);

        // R10: start in the done cycle of the previous division
        base = n_done;
        issue(16'hA123, 16'h8F00, "R5", "R1");
        wait (n_done == base + 1);
        issue(16'hE000, 16'hB111, "R5", "R10");
        wait (n_done == base + 2);

        // R4/R5: random normalized operands, back to back
        for (int i = 0; i < 400; i++) begin
            logic [DW-1:0] x;
            logic [DW-1:0] d;
            x = {1'b1, DW'($urandom) & {1'b0, {(DW-1){1'b1}}}} | (DW'(1) << (DW-1));
            d = {1'b1, (DW-1)'($urandom)};
            x[DW-1] = 1'b1;
            run(x, d, "R4/R5");
        end

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R2", "pending items at end", sb.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: an expired run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule